// File: doc/BRIEF.md
# Writeback Hazard Scoreboard

This block is the issue-control logic of a five-stage in-order pipeline whose stages are instruction fetch, decode, execute, memory access and register writeback. The register file holds sixteen 32-bit registers and has two write ports. One port serves register-to-register results and the other serves load data. The scoreboard keeps one busy flag per register. The decode stage presents the operand and destination indices of the next instruction, and the scoreboard either accepts the instruction or holds it.

A memory read can stay in the memory stage for two or more cycles. It leaves that stage when the memory reports completion. The load does not block instructions that come after it. A later register-to-register instruction that neither reads nor writes the load's destination issues at once. It can write back before the load, or in the same cycle as the load through the other port. Decode is held only on a true read-after-write dependency, on a write-after-write conflict, or when a second load arrives while the single load slot is still occupied.

Top module: `wb_scoreboard`

## Requirements
- R1: After reset, both writeback enables are low and no register is busy, so any valid instruction is accepted without a stall.
- R2: `id_stall` is high only while `id_valid` is high. An operand whose use flag is low never causes a stall, even if its register is busy. An operand whose use flag is high stalls decode while its register is busy.
- R3: An instruction that writes a register (a load, or `id_rd_we` high) stalls while its destination register is busy. This covers a busy register whether the earlier writer was a load or a register-to-register instruction.
- R4: A register-to-register instruction with `id_rd_we` high drives `alu_wb_en` high for exactly one cycle, with `alu_wb_idx` equal to its destination. This happens ALU_LAT-1 clock edges after the edge that accepts it; the default ALU_LAT is 3. An instruction with `id_rd_we` low produces no writeback.
- R5: An accepted load stays in the memory stage until `mem_done` is sampled high at a clock edge. Starting at that edge, `load_wb_en` is high for one cycle with `load_wb_idx` equal to the load's destination.
- R6: While a load waits in the memory stage, register-to-register instructions that do not touch its destination are accepted without a stall and can write back before the load does.
- R7: Both writeback enables can be high in the same cycle, and their indices then always differ.
- R8: A register stays busy through its writeback cycle and becomes free at the next clock edge. A dependent instruction presented in the cycle right after its producer is therefore held for ALU_LAT cycles behind a register-to-register producer.
- R9: Only one load can be in the memory stage at a time. A second load stalls until the first one's writeback cycle, and it may be accepted at the edge that ends that cycle.
- R10: `mem_done` has no effect when no load is in the memory stage. It neither produces a load writeback nor completes a load that is accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| id_valid | input | 1 | Decode holds an instruction |
| id_rs1 | input | 4 | First operand register index |
| id_rs1_use | input | 1 | First operand is read |
| id_rs2 | input | 4 | Second operand register index |
| id_rs2_use | input | 1 | Second operand is read |
| id_rd | input | 4 | Destination register index |
| id_rd_we | input | 1 | Register-to-register instruction writes its destination |
| id_is_load | input | 1 | Instruction is a memory read; it always writes its destination |
| mem_done | input | 1 | Memory stage finished the pending read |
| id_stall | output | 1 | Hold decode this cycle |
| alu_wb_en | output | 1 | Register-to-register write port enable |
| alu_wb_idx | output | 4 | Register-to-register write port index |
| load_wb_en | output | 1 | Load write port enable |
| load_wb_idx | output | 4 | Load write port index |

## Verification
The properties assume that decode keeps an instruction steady while it is stalled. They also assume that a load presents its destination as written, and that `mem_done` is a single-cycle pulse that matters only while a load is waiting. Every bench sequence keeps a held instruction unchanged until it is accepted. Pulses on `mem_done` with no load in flight are applied on purpose, to show that they are ignored. The full sweep over destination and operand pairs waits for the pipe to drain after each pair, so that each stall count depends only on the pair under test.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    LSLOT_IDLE = 1'b0,
    LSLOT_WAIT = 1'b1
  } lslot_state_t;
endpackage

// File: rtl/sb_pending_table.sv
module sb_pending_table #(
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_a_en,
  input  logic [IDX_W-1:0] clr_a_idx,
  input  logic             clr_b_en,
  input  logic [IDX_W-1:0] clr_b_idx,
  output logic [NREGS-1:0] busy
);
  for (genvar r = 0; r < NREGS; r++) begin : g_bit
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(r));
    assign hit_clr = (clr_a_en && (clr_a_idx == IDX_W'(r))) ||
                     (clr_b_en && (clr_b_idx == IDX_W'(r)));
    always_ff @(posedge clk) begin
      if (rst)          busy[r] <= 1'b0;
      else if (hit_set) busy[r] <= 1'b1;
      else if (hit_clr) busy[r] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_alu_pipe.sv
module sb_alu_pipe #(
  parameter int IDX_W   = 4,
  parameter int ALU_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic [IDX_W-1:0] in_idx,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx
);
  logic             stg_v   [ALU_LAT];
  logic [IDX_W-1:0] stg_idx [ALU_LAT];

  for (genvar s = 0; s < ALU_LAT; s++) begin : g_stage
    logic             nxt_v;
    logic [IDX_W-1:0] nxt_idx;
    if (s == 0) begin : g_head
      assign nxt_v   = in_en;
      assign nxt_idx = in_idx;
    end else begin : g_body
      assign nxt_v   = stg_v[s-1];
      assign nxt_idx = stg_idx[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_v[s]   <= 1'b0;
        stg_idx[s] <= '0;
      end else begin
        stg_v[s]   <= nxt_v;
        stg_idx[s] <= nxt_idx;
      end
    end
  end

  assign wb_en  = stg_v[ALU_LAT-1];
  assign wb_idx = stg_idx[ALU_LAT-1];
endmodule

// File: rtl/sb_load_slot.sv
module sb_load_slot
  import sb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [IDX_W-1:0] issue_idx,
  input  logic             mem_done,
  output logic             occupied,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx
);
  lslot_state_t     state;
  logic [IDX_W-1:0] held_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LSLOT_IDLE;
      held_idx <= '0;
      wb_en    <= 1'b0;
      wb_idx   <= '0;
    end else begin
      wb_en <= 1'b0;
      case (state)
        LSLOT_IDLE: begin
          if (issue) begin
            state    <= LSLOT_WAIT;
            held_idx <= issue_idx;
          end
        end
        LSLOT_WAIT: begin
          if (mem_done) begin
            state  <= LSLOT_IDLE;
            wb_en  <= 1'b1;
            wb_idx <= held_idx;
          end
        end
        default: state <= LSLOT_IDLE;
      endcase
    end
  end

  assign occupied = (state == LSLOT_WAIT);
endmodule

// File: rtl/wb_scoreboard.sv
module wb_scoreboard #(
  parameter int NREGS   = 16,
  parameter int ALU_LAT = 3,
  localparam int IDX_W  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic             id_rs1_use,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic             id_rs2_use,
  input  logic [IDX_W-1:0] id_rd,
  input  logic             id_rd_we,
  input  logic             id_is_load,
  input  logic             mem_done,
  output logic             id_stall,
  output logic             alu_wb_en,
  output logic [IDX_W-1:0] alu_wb_idx,
  output logic             load_wb_en,
  output logic [IDX_W-1:0] load_wb_idx
);
  logic [NREGS-1:0] pend;
  logic             slot_full;
  logic             writes_rd;
  logic             raw_hit;
  logic             waw_hit;
  logic             slot_hit;
  logic             accept;

  assign writes_rd = id_is_load || id_rd_we;
  assign raw_hit   = (id_rs1_use && pend[id_rs1]) || (id_rs2_use && pend[id_rs2]);
  assign waw_hit   = writes_rd && pend[id_rd];
  assign slot_hit  = id_is_load && slot_full;
  assign id_stall  = id_valid && (raw_hit || waw_hit || slot_hit);
  assign accept    = id_valid && !id_stall;

  sb_pending_table #(.NREGS(NREGS)) u_table (
    .clk       (clk),
    .rst       (rst),
    .set_en    (accept && writes_rd),
    .set_idx   (id_rd),
    .clr_a_en  (alu_wb_en),
    .clr_a_idx (alu_wb_idx),
    .clr_b_en  (load_wb_en),
    .clr_b_idx (load_wb_idx),
    .busy      (pend)
  );

  sb_alu_pipe #(.IDX_W(IDX_W), .ALU_LAT(ALU_LAT)) u_alu (
    .clk    (clk),
    .rst    (rst),
    .in_en  (accept && !id_is_load && id_rd_we),
    .in_idx (id_rd),
    .wb_en  (alu_wb_en),
    .wb_idx (alu_wb_idx)
  );

  sb_load_slot #(.IDX_W(IDX_W)) u_load (
    .clk       (clk),
    .rst       (rst),
    .issue     (accept && id_is_load),
    .issue_idx (id_rd),
    .mem_done  (mem_done),
    .occupied  (slot_full),
    .wb_en     (load_wb_en),
    .wb_idx    (load_wb_idx)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NREGS = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             id_valid,
  input logic             id_stall,
  input logic             mem_done,
  input logic             alu_wb_en,
  input logic [IDX_W-1:0] alu_wb_idx,
  input logic             load_wb_en,
  input logic [IDX_W-1:0] load_wb_idx,
  input logic [NREGS-1:0] pend
);
  assert_idle_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> !id_stall);

  assert_dual_wb_distinct_R7: assert property (@(posedge clk) disable iff (rst)
    (alu_wb_en && load_wb_en) |-> (alu_wb_idx != load_wb_idx));

  assert_load_wb_single_R5: assert property (@(posedge clk) disable iff (rst)
    load_wb_en |=> !load_wb_en);

  assert_load_wb_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(load_wb_en) |-> $past(mem_done));

  assert_alu_wb_target_busy_R8: assert property (@(posedge clk) disable iff (rst)
    alu_wb_en |-> pend[alu_wb_idx]);

  assert_load_wb_target_busy_R8: assert property (@(posedge clk) disable iff (rst)
    load_wb_en |-> pend[load_wb_idx]);

  assert_wb_frees_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (alu_wb_en && !(load_wb_en && load_wb_idx == alu_wb_idx)) |=> !pend[$past(alu_wb_idx)]);
endmodule

bind wb_scoreboard sb_checker #(.NREGS(NREGS), .IDX_W(IDX_W)) u_sb_checker (
  .clk         (clk),
  .rst         (rst),
  .id_valid    (id_valid),
  .id_stall    (id_stall),
  .mem_done    (mem_done),
  .alu_wb_en   (alu_wb_en),
  .alu_wb_idx  (alu_wb_idx),
  .load_wb_en  (load_wb_en),
  .load_wb_idx (load_wb_idx),
  .pend        (pend)
);

// File: tb/test_wb_scoreboard.sv
module test_wb_scoreboard;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 16;
  localparam int ALU_LAT    = 3;
  localparam int IDX_W      = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             id_valid = 1'b0;
  logic [IDX_W-1:0] id_rs1 = '0;
  logic             id_rs1_use = 1'b0;
  logic [IDX_W-1:0] id_rs2 = '0;
  logic             id_rs2_use = 1'b0;
  logic [IDX_W-1:0] id_rd = '0;
  logic             id_rd_we = 1'b0;
  logic             id_is_load = 1'b0;
  logic             mem_done = 1'b0;
  logic             id_stall;
  logic             alu_wb_en;
  logic [IDX_W-1:0] alu_wb_idx;
  logic             load_wb_en;
  logic [IDX_W-1:0] load_wb_idx;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int last_alu_idx = -1;
  int last_alu_cyc = -1;

  wb_scoreboard #(.NREGS(NREGS), .ALU_LAT(ALU_LAT)) i_wb_scoreboard (
    .clk(clk), .rst(rst), .id_valid(id_valid),
    .id_rs1(id_rs1), .id_rs1_use(id_rs1_use),
    .id_rs2(id_rs2), .id_rs2_use(id_rs2_use),
    .id_rd(id_rd), .id_rd_we(id_rd_we), .id_is_load(id_is_load),
    .mem_done(mem_done), .id_stall(id_stall),
    .alu_wb_en(alu_wb_en), .alu_wb_idx(alu_wb_idx),
    .load_wb_en(load_wb_en), .load_wb_idx(load_wb_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (alu_wb_en) begin
      last_alu_idx <= int'(alu_wb_idx);
      last_alu_cyc <= cyc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  // drive one decode cycle, sample stall before the edge, return after it
  task automatic tick(input logic v, input int rs1, input logic u1,
                      input int rs2, input logic u2, input int rd,
                      input logic we, input logic ld, input logic md,
                      output int st);
    id_valid = v; id_rs1 = IDX_W'(rs1); id_rs1_use = u1;
    id_rs2 = IDX_W'(rs2); id_rs2_use = u2; id_rd = IDX_W'(rd);
    id_rd_we = we; id_is_load = ld; mem_done = md;
    #1 st = int'(id_stall);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic md);
    int st;
    tick(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, md, st);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int st;
    int k;
    int issue_c;
    repeat (3) @(negedge clk);
    check("R1 alu_wb_en in reset", int'(alu_wb_en), 0);
    check("R1 load_wb_en in reset", int'(load_wb_en), 0);
    rst = 1'b0;
    tick(1'b1, 15, 1'b1, 14, 1'b1, 13, 1'b1, 1'b0, 1'b0, st);
    check("R1 first instruction not stalled", st, 0);
    repeat (4) idle(1'b0);

    // R2/R4/R8 sweep over every destination and operand pair
    for (int rd = 0; rd < NREGS; rd++) begin
      for (int src = 0; src < NREGS; src++) begin
        tick(1'b1, 0, 1'b0, 0, 1'b0, rd, 1'b1, 1'b0, 1'b0, st);
        check("R2 producer with no busy regs", st, 0);
        issue_c = cyc;
        k = 0;
        do begin
          tick(1'b1, src, (rd % 2) == 0, src, (rd % 2) == 1, 0, 1'b0, 1'b0, 1'b0, st);
          if (st != 0) k++;
        end while (st != 0 && k < 10);
        check("R8 dependent stall cycles", k, (src == rd) ? ALU_LAT : 0);
        repeat (3) idle(1'b0);
        check("R4 alu writeback index", last_alu_idx, rd);
        check("R4 alu writeback cycle", last_alu_cyc, issue_c + ALU_LAT - 1);
      end
    end

    // R5/R6/R7/R8 load overtaken by independent instructions
    tick(1'b1, 0, 1'b0, 0, 1'b0, 5, 1'b1, 1'b1, 1'b0, st);
    check("R6 load accepted", st, 0);
    tick(1'b1, 2, 1'b1, 3, 1'b1, 1, 1'b1, 1'b0, 1'b0, st);
    check("R6 independent op 1 not stalled", st, 0);
    check("R5 load still waiting", int'(load_wb_en), 0);
    tick(1'b1, 6, 1'b1, 7, 1'b1, 2, 1'b1, 1'b0, 1'b0, st);
    check("R6 independent op 2 not stalled", st, 0);
    idle(1'b0);
    check("R6 op 1 writes back ahead of load", int'(alu_wb_en), 1);
    check("R6 op 1 index", int'(alu_wb_idx), 1);
    check("R5 no load writeback before mem_done", int'(load_wb_en), 0);
    idle(1'b1);
    check("R7 alu port active", int'(alu_wb_en), 1);
    check("R7 alu index", int'(alu_wb_idx), 2);
    check("R5 load writeback after mem_done", int'(load_wb_en), 1);
    check("R5 load index", int'(load_wb_idx), 5);
    tick(1'b1, 5, 1'b1, 0, 1'b0, 8, 1'b1, 1'b0, 1'b0, st);
    check("R8 reader held in load writeback cycle", st, 1);
    check("R5 load writeback lasts one cycle", int'(load_wb_en), 0);
    tick(1'b1, 5, 1'b1, 0, 1'b0, 8, 1'b1, 1'b0, 1'b0, st);
    check("R8 reader accepted once register freed", st, 0);
    repeat (4) idle(1'b0);

    // R2 unused operands and invalid decode never stall
    tick(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1, 1'b1, 1'b0, st);
    tick(1'b1, 7, 1'b0, 7, 1'b0, 1, 1'b1, 1'b0, 1'b0, st);
    check("R2 unused operands on busy reg", st, 0);
    tick(1'b0, 7, 1'b1, 7, 1'b1, 7, 1'b1, 1'b1, 1'b0, st);
    check("R2 invalid decode not stalled", st, 0);
    tick(1'b1, 7, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1, st);
    check("R2 used operand on busy load reg", st, 1);
    check("R5 load r7 writeback", int'(load_wb_idx), 7);
    tick(1'b1, 7, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, st);
    check("R8 held during load writeback", st, 1);
    tick(1'b1, 7, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, st);
    check("R8 accepted after free", st, 0);
    repeat (4) idle(1'b0);

    // R3 write-after-write on a load and on an alu result
    tick(1'b1, 0, 1'b0, 0, 1'b0, 9, 1'b1, 1'b1, 1'b0, st);
    k = 0;
    do begin
      tick(1'b1, 0, 1'b0, 0, 1'b0, 9, 1'b1, 1'b0, (k == 0), st);
      if (st != 0) k++;
    end while (st != 0 && k < 10);
    check("R3 writer behind load stall cycles", k, 2);
    repeat (4) idle(1'b0);
    tick(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1, 1'b0, 1'b0, st);
    k = 0;
    do begin
      tick(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1, 1'b0, 1'b0, st);
      if (st != 0) k++;
    end while (st != 0 && k < 10);
    check("R3 writer behind alu stall cycles", k, ALU_LAT);
    repeat (4) idle(1'b0);

    // R9 single load slot
    tick(1'b1, 0, 1'b0, 0, 1'b0, 3, 1'b1, 1'b1, 1'b0, st);
    tick(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1, 1'b1, 1'b0, st);
    check("R9 second load stalled", st, 1);
    tick(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1, 1'b1, 1'b1, st);
    check("R9 second load stalled on done edge", st, 1);
    check("R9 first load writeback index", int'(load_wb_idx), 3);
    tick(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1, 1'b1, 1'b0, st);
    check("R9 second load accepted in writeback cycle", st, 0);
    idle(1'b1);
    check("R9 second load writeback", int'(load_wb_en), 1);
    check("R9 second load index", int'(load_wb_idx), 4);
    repeat (4) idle(1'b0);

    // R10 stray completion pulses
    idle(1'b1);
    check("R10 stray done no writeback", int'(load_wb_en), 0);
    idle(1'b1);
    check("R10 second stray done no writeback", int'(load_wb_en), 0);
    tick(1'b1, 0, 1'b0, 0, 1'b0, 3, 1'b1, 1'b1, 1'b0, st);
    idle(1'b0);
    check("R10 later load not pre-completed", int'(load_wb_en), 0);
    idle(1'b1);
    check("R10 later load completes on own done", int'(load_wb_en), 1);
    repeat (4) idle(1'b0);

    summary();
    $finish;
  end
endmodule